// File: doc/BRIEF.md
# UART Interrupt Identification Controller

This block decides which interrupt a 16550-style UART reports and drives its interrupt line. The receive and transmit paths, the FIFOs, the modem input logic and the busy tracker feed it their events. The block latches the sources that must persist and follows the sources that are defined by a level. It resolves them by a fixed priority and presents a 4-bit identification code. Software reads that code to learn the cause, and then services the cause through the usual register accesses.

The block watches the bus read and write strobes with their register select. Each source is removed by its own access: a read of the line status, receive buffer, modem status or UART status register, a write of the transmit holding register, or a read of the identification register itself. A character-timeout detector counts character periods, which arrive as one-cycle ticks from the baud logic, while the receive FIFO holds data without traffic.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset `irqId` is 4'b0001 and `irqOut` is low. The codes are 0110 line status, 1100 character timeout, 0100 received data, 0010 transmitter empty, 0000 modem status, 0111 busy detect and 0001 none. `irqOut` is high exactly when `irqId` is not 0001.
- R2: When several sources are pending, the one reported is the first in this order: line status, character timeout, received data, transmitter empty, modem status, busy detect.
- R3: Any bit of `lineErrors` sets a sticky line-status source. It stays set until a read with `regSel`=5, and a new error in the same cycle as that read keeps it set.
- R4: With `fifoEnable` low, an `rxPush` sets the received-data source and a read with `regSel`=0 clears it. With `fifoEnable` high, the source follows `rxAtTrigger`.
- R5: With `fifoEnable` and `rxNotEmpty` high, the 4th `charTick` without any `rxPush` or `rxPop` sets the character timeout. A push or pop restarts the count. A read with `regSel`=0 clears it.
- R6: Outside threshold mode, a rising edge of `txEmpty` sets the transmitter-empty source. A write with `regSel`=0 clears it. A read with `regSel`=2 clears it only when 0010 is the code being reported.
- R7: With both `fifoEnable` and `txThreshMode` high, the transmitter source follows `txAtThresh` and is not removed by an identification read.
- R8: Any bit of `modemDelta` sets the modem-status source. Only a read with `regSel`=6 clears it.
- R9: A write with `regSel`=3 while `uartBusy` is high sets busy detect, and the same write with `uartBusy` low does nothing. A read with `regSel`=7 clears it.
- R10: `irqEnable` bit 2 gates line status, bit 0 gates received data and timeout, bit 1 gates transmitter empty and bit 3 gates modem status. Busy detect is always enabled. A disabled source keeps its latched state.
- R11: A latched source changes state at the clock edge that samples its event or access. Enables and level sources reach `irqId` without a register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busRead | input | 1 | Register read strobe |
| busWrite | input | 1 | Register write strobe |
| regSel | input | 3 | Register select for the access |
| irqEnable | input | 4 | Per-source interrupt enables |
| fifoEnable | input | 1 | FIFO mode |
| txThreshMode | input | 1 | Programmable transmit threshold mode |
| lineErrors | input | 4 | Overrun, parity, framing and break event pulses |
| rxPush | input | 1 | A character entered the receive path |
| rxPop | input | 1 | A character left the receive FIFO |
| rxNotEmpty | input | 1 | Receive FIFO holds data |
| rxAtTrigger | input | 1 | Receive level at or above the trigger |
| charTick | input | 1 | One-cycle pulse per character period |
| txEmpty | input | 1 | Transmit holding register empty |
| txAtThresh | input | 1 | Transmit FIFO at or below the threshold |
| modemDelta | input | 4 | Modem line change pulses |
| uartBusy | input | 1 | UART busy flag |
| irqId | output | 4 | Interrupt identification code |
| irqOut | output | 1 | Interrupt request line |

## Verification
An event or access driven before a rising edge shows up in `irqId` after that edge, so the bench drives inputs after the falling edge and samples at the next falling edge, one cycle later. A change of an enable or a level input (`rxAtTrigger`, `txAtThresh`) alters `irqId` in the same cycle, and the bench checks it 1 ns after the change with no edge in between. The timeout is checked at the exact boundary: no report after the 3rd tick and a report after the 4th.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef enum logic [3:0] {
    ID_MODEM   = 4'b0000,
    ID_NONE    = 4'b0001,
    ID_TX      = 4'b0010,
    ID_RXDATA  = 4'b0100,
    ID_LINE    = 4'b0110,
    ID_BUSY    = 4'b0111,
    ID_TIMEOUT = 4'b1100
  } irq_id_e;

  // decoded register accesses passed from control to datapath
  typedef struct packed {
    logic rdRxBuf;
    logic wrTxHold;
    logic rdIdent;
    logic wrLineCtl;
    logic rdLineStat;
    logic rdModemStat;
    logic rdUartStat;
  } acc_strobe_t;

  localparam int SEL_DATA  = 0;
  localparam int SEL_IDENT = 2;
  localparam int SEL_LCTL  = 3;
  localparam int SEL_LSTAT = 5;
  localparam int SEL_MSTAT = 6;
  localparam int SEL_USTAT = 7;

  localparam int EN_RX    = 0;
  localparam int EN_TX    = 1;
  localparam int EN_LINE  = 2;
  localparam int EN_MODEM = 3;

endpackage

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             busRead,
  input  logic             busWrite,
  input  logic [SEL_W-1:0] regSel,
  output acc_strobe_t      strb
);

  localparam logic [SEL_W-1:0] S_DATA  = SEL_W'(SEL_DATA);
  localparam logic [SEL_W-1:0] S_IDENT = SEL_W'(SEL_IDENT);
  localparam logic [SEL_W-1:0] S_LCTL  = SEL_W'(SEL_LCTL);
  localparam logic [SEL_W-1:0] S_LSTAT = SEL_W'(SEL_LSTAT);
  localparam logic [SEL_W-1:0] S_MSTAT = SEL_W'(SEL_MSTAT);
  localparam logic [SEL_W-1:0] S_USTAT = SEL_W'(SEL_USTAT);

  always_comb begin
    strb             = '0;
    strb.rdRxBuf     = busRead  && (regSel == S_DATA);
    strb.wrTxHold    = busWrite && (regSel == S_DATA);
    strb.rdIdent     = busRead  && (regSel == S_IDENT);
    strb.wrLineCtl   = busWrite && (regSel == S_LCTL);
    strb.rdLineStat  = busRead  && (regSel == S_LSTAT);
    strb.rdModemStat = busRead  && (regSel == S_MSTAT);
    strb.rdUartStat  = busRead  && (regSel == S_USTAT);
  end

endmodule

// File: rtl/uart_irq_sticky.sv
module uart_irq_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic setIn,
  input  logic clrIn,
  output logic q
);

  // a new event in the clearing cycle wins over the clear
  always_ff @(posedge clk) begin
    if (!rst_n) q <= 1'b0;
    else        q <= setIn | (q & ~clrIn);
  end

endmodule

// File: rtl/uart_irq_timeout.sv
module uart_irq_timeout #(
  parameter int CHARS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic restart,
  input  logic charTick,
  input  logic clr,
  output logic flag
);

  localparam int CW = $clog2(CHARS + 1);
  localparam logic [CW-1:0] LAST = CW'(CHARS - 1);
  localparam logic [CW-1:0] FULL = CW'(CHARS);

  logic [CW-1:0] cnt;
  logic          hit;

  assign hit = active & ~restart & charTick & (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else begin
      if (restart || !active)          cnt <= '0;
      else if (charTick && cnt != FULL) cnt <= cnt + 1'b1;
      flag <= hit | (flag & ~clr);
    end
  end

  // R5: the timeout only appears on a character tick
  assert_timeout_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(charTick));

  // R5: the period count never runs past its limit
  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);

endmodule

// File: rtl/uart_irq_datapath.sv
module uart_irq_datapath
  import uart_irq_pkg::*;
#(
  parameter int LINE_ERR_W    = 4,
  parameter int MODEM_W       = 4,
  parameter int TIMEOUT_CHARS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  acc_strobe_t           strb,
  input  logic [3:0]            irqEnable,
  input  logic                  fifoEnable,
  input  logic                  txThreshMode,
  input  logic [LINE_ERR_W-1:0] lineErrors,
  input  logic                  rxPush,
  input  logic                  rxPop,
  input  logic                  rxNotEmpty,
  input  logic                  rxAtTrigger,
  input  logic                  charTick,
  input  logic                  txEmpty,
  input  logic                  txAtThresh,
  input  logic [MODEM_W-1:0]    modemDelta,
  input  logic                  uartBusy,
  output logic [3:0]            irqId
);

  localparam int SRC_LINE  = 0;
  localparam int SRC_RXD   = 1;
  localparam int SRC_TX    = 2;
  localparam int SRC_MODEM = 3;
  localparam int SRC_BUSY  = 4;
  localparam int NSRC      = 5;

  logic [NSRC-1:0] setVec;
  logic [NSRC-1:0] clrVec;
  logic [NSRC-1:0] held;
  logic            txEmptyQ;
  logic            toFlag;
  logic            txRise;
  logic            reportedTx;
  irq_id_e         idSel;

  always_ff @(posedge clk) begin
    if (!rst_n) txEmptyQ <= 1'b1;
    else        txEmptyQ <= txEmpty;
  end

  assign txRise     = txEmpty & ~txEmptyQ;
  assign reportedTx = (idSel == ID_TX);

  always_comb begin
    setVec[SRC_LINE]  = |lineErrors;
    clrVec[SRC_LINE]  = strb.rdLineStat;
    setVec[SRC_RXD]   = rxPush & ~fifoEnable;
    clrVec[SRC_RXD]   = strb.rdRxBuf;
    setVec[SRC_TX]    = txRise;
    clrVec[SRC_TX]    = strb.wrTxHold | (strb.rdIdent & reportedTx);
    setVec[SRC_MODEM] = |modemDelta;
    clrVec[SRC_MODEM] = strb.rdModemStat;
    setVec[SRC_BUSY]  = strb.wrLineCtl & uartBusy;
    clrVec[SRC_BUSY]  = strb.rdUartStat;
  end

  for (genvar g = 0; g < NSRC; g++) begin : gSrc
    uart_irq_sticky u_src (
      .clk   (clk),
      .rst_n (rst_n),
      .setIn (setVec[g]),
      .clrIn (clrVec[g]),
      .q     (held[g])
    );
  end

  uart_irq_timeout #(.CHARS(TIMEOUT_CHARS)) u_timeout (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (fifoEnable & rxNotEmpty),
    .restart  (rxPush | rxPop),
    .charTick (charTick),
    .clr      (strb.rdRxBuf),
    .flag     (toFlag)
  );

  logic lineP, toP, rxdP, txP, modP, busyP;

  always_comb begin
    lineP = held[SRC_LINE] & irqEnable[EN_LINE];
    toP   = toFlag & irqEnable[EN_RX];
    rxdP  = (fifoEnable ? rxAtTrigger : held[SRC_RXD]) & irqEnable[EN_RX];
    txP   = ((fifoEnable & txThreshMode) ? txAtThresh : held[SRC_TX]) & irqEnable[EN_TX];
    modP  = held[SRC_MODEM] & irqEnable[EN_MODEM];
    busyP = held[SRC_BUSY];
  end

  always_comb begin
    if      (lineP) idSel = ID_LINE;
    else if (toP)   idSel = ID_TIMEOUT;
    else if (rxdP)  idSel = ID_RXDATA;
    else if (txP)   idSel = ID_TX;
    else if (modP)  idSel = ID_MODEM;
    else if (busyP) idSel = ID_BUSY;
    else            idSel = ID_NONE;
  end

  assign irqId = idSel;

  // R3: a line error stays latched until the line status read
  assert_line_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    held[SRC_LINE] && !strb.rdLineStat |=> held[SRC_LINE]);

  // R9: a control write while busy always latches busy detect
  assert_busy_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    strb.wrLineCtl && uartBusy |=> held[SRC_BUSY]);

  // R6: a holding register write removes the transmitter source
  assert_tx_write_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    strb.wrTxHold && !txRise |=> !held[SRC_TX]);

  // R8: a modem status read removes the modem source
  assert_modem_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strb.rdModemStat && !(|modemDelta) |=> !held[SRC_MODEM]);

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int SEL_W         = 3,
  parameter int LINE_ERR_W    = 4,
  parameter int MODEM_W       = 4,
  parameter int TIMEOUT_CHARS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  busRead,
  input  logic                  busWrite,
  input  logic [SEL_W-1:0]      regSel,
  input  logic [3:0]            irqEnable,
  input  logic                  fifoEnable,
  input  logic                  txThreshMode,
  input  logic [LINE_ERR_W-1:0] lineErrors,
  input  logic                  rxPush,
  input  logic                  rxPop,
  input  logic                  rxNotEmpty,
  input  logic                  rxAtTrigger,
  input  logic                  charTick,
  input  logic                  txEmpty,
  input  logic                  txAtThresh,
  input  logic [MODEM_W-1:0]    modemDelta,
  input  logic                  uartBusy,
  output logic [3:0]            irqId,
  output logic                  irqOut
);

  acc_strobe_t strb;

  uart_irq_ctrl #(.SEL_W(SEL_W)) u_ctrl (
    .busRead  (busRead),
    .busWrite (busWrite),
    .regSel   (regSel),
    .strb     (strb)
  );

  uart_irq_datapath #(
    .LINE_ERR_W    (LINE_ERR_W),
    .MODEM_W       (MODEM_W),
    .TIMEOUT_CHARS (TIMEOUT_CHARS)
  ) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .strb         (strb),
    .irqEnable    (irqEnable),
    .fifoEnable   (fifoEnable),
    .txThreshMode (txThreshMode),
    .lineErrors   (lineErrors),
    .rxPush       (rxPush),
    .rxPop        (rxPop),
    .rxNotEmpty   (rxNotEmpty),
    .rxAtTrigger  (rxAtTrigger),
    .charTick     (charTick),
    .txEmpty      (txEmpty),
    .txAtThresh   (txAtThresh),
    .modemDelta   (modemDelta),
    .uartBusy     (uartBusy),
    .irqId        (irqId)
  );

  assign irqOut = (irqId != ID_NONE);

  // R2: an enabled line error is reported one edge after it arrives
  assert_line_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|lineErrors) && irqEnable[EN_LINE] && $stable(irqEnable) |=> irqId == ID_LINE);

endmodule

// File: tb/uart_irq_ident_tb.sv
module uart_irq_ident_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       busRead = 1'b0, busWrite = 1'b0;
  logic [2:0] regSel = '0;
  logic [3:0] irqEnable = 4'hF;
  logic       fifoEnable = 1'b0, txThreshMode = 1'b0;
  logic [3:0] lineErrors = '0;
  logic       rxPush = 1'b0, rxPop = 1'b0, rxNotEmpty = 1'b0, rxAtTrigger = 1'b0;
  logic       charTick = 1'b0, txEmpty = 1'b1, txAtThresh = 1'b0;
  logic [3:0] modemDelta = '0;
  logic       uartBusy = 1'b0;
  logic [3:0] irqId;
  logic       irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  logic mLine, mRxd, mTx, mMod, mBusy, mTxQ, mFlag;
  int   mCnt;

  always #5 clk = ~clk;

  uart_irq_ident u_dut (
    .clk(clk), .rst_n(rst_n), .busRead(busRead), .busWrite(busWrite),
    .regSel(regSel), .irqEnable(irqEnable), .fifoEnable(fifoEnable),
    .txThreshMode(txThreshMode), .lineErrors(lineErrors), .rxPush(rxPush),
    .rxPop(rxPop), .rxNotEmpty(rxNotEmpty), .rxAtTrigger(rxAtTrigger),
    .charTick(charTick), .txEmpty(txEmpty), .txAtThresh(txAtThresh),
    .modemDelta(modemDelta), .uartBusy(uartBusy), .irqId(irqId), .irqOut(irqOut)
  );

  function automatic logic [3:0] expId();
    logic rxd, tx;
    rxd = (fifoEnable ? rxAtTrigger : mRxd) & irqEnable[0];
    tx  = ((fifoEnable & txThreshMode) ? txAtThresh : mTx) & irqEnable[1];
    if (mLine & irqEnable[2])      return 4'b0110;
    if (mFlag & irqEnable[0])      return 4'b1100;
    if (rxd)                       return 4'b0100;
    if (tx)                        return 4'b0010;
    if (mMod & irqEnable[3])       return 4'b0000;
    if (mBusy)                     return 4'b0111;
    return 4'b0001;
  endfunction

  task automatic modelReset();
    mLine = 0; mRxd = 0; mTx = 0; mMod = 0; mBusy = 0; mTxQ = 1; mFlag = 0; mCnt = 0;
  endtask

  task automatic clearPulses();
    busRead = 0; busWrite = 0; lineErrors = '0; rxPush = 0; rxPop = 0;
    charTick = 0; modemDelta = '0;
  endtask

  // one clock: compute next reference state, take the edge, return at negedge
  task automatic step();
    logic [3:0] cur;
    logic rdRbr, wrThr, rdId, wrLcr, rdLsr, rdMsr, rdUsr, act, rst, hit;
    logic nLine, nRxd, nTx, nMod, nBusy, nFlag;
    int nCnt;
    cur   = expId();
    rdRbr = busRead  && regSel == 3'd0;
    wrThr = busWrite && regSel == 3'd0;
    rdId  = busRead  && regSel == 3'd2;
    wrLcr = busWrite && regSel == 3'd3;
    rdLsr = busRead  && regSel == 3'd5;
    rdMsr = busRead  && regSel == 3'd6;
    rdUsr = busRead  && regSel == 3'd7;
    nLine = (|lineErrors) | (mLine & !rdLsr);
    nRxd  = (rxPush & !fifoEnable) | (mRxd & !rdRbr);
    nTx   = (txEmpty & !mTxQ) | (mTx & !(wrThr | (rdId && cur == 4'b0010)));
    nMod  = (|modemDelta) | (mMod & !rdMsr);
    nBusy = (wrLcr & uartBusy) | (mBusy & !rdUsr);
    act   = fifoEnable & rxNotEmpty;
    rst   = rxPush | rxPop;
    hit   = act & !rst & charTick & (mCnt == 3);
    if (rst || !act)              nCnt = 0;
    else if (charTick && mCnt < 4) nCnt = mCnt + 1;
    else                          nCnt = mCnt;
    nFlag = hit | (mFlag & !rdRbr);
    @(posedge clk);
    mLine = nLine; mRxd = nRxd; mTx = nTx; mMod = nMod; mBusy = nBusy;
    mFlag = nFlag; mCnt = nCnt; mTxQ = txEmpty;
    @(negedge clk);
    clearPulses();
  endtask

  task automatic checkId(string tag, logic [3:0] exp);
    checks++;
    if (irqId !== exp || irqOut !== (exp != 4'b0001)) begin
      errors++;
      $display("FAIL %s: irqId=%b irqOut=%b expected irqId=%b irqOut=%b",
               tag, irqId, irqOut, exp, exp != 4'b0001);
    end
  endtask

  task automatic access(bit rd, logic [2:0] sel);
    busRead = rd; busWrite = !rd; regSel = sel;
    step();
  endtask

  task automatic txPulse();
    txEmpty = 0; step(); txEmpty = 1; step();
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    modelReset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    checkId("R1 reset", 4'b0001);

    // busy detect
    uartBusy = 0; access(0, 3'd3);
    checkId("R9 write not busy ignored", 4'b0001);
    uartBusy = 1; access(0, 3'd3); uartBusy = 0;
    checkId("R9 busy set", 4'b0111);
    access(1, 3'd7);
    checkId("R9 busy cleared", 4'b0001);

    // modem status
    modemDelta = 4'b0010; step();
    checkId("R8 modem set", 4'b0000);
    access(1, 3'd2);
    checkId("R8 ident read keeps modem", 4'b0000);
    access(1, 3'd6);
    checkId("R8 modem cleared", 4'b0001);

    // transmitter empty
    txPulse();
    checkId("R6 tx set on rise", 4'b0010);
    access(1, 3'd2);
    checkId("R6 ident read clears reported tx", 4'b0001);
    txPulse();
    access(0, 3'd0);
    checkId("R6 holding write clears tx", 4'b0001);
    txPulse();
    modemDelta = 4'b1000; step();
    checkId("R2 tx above modem", 4'b0010);
    access(1, 3'd2);
    checkId("R2 modem after tx cleared", 4'b0000);
    txPulse();
    lineErrors = 4'b0001; step();
    checkId("R2 line above tx", 4'b0110);
    access(1, 3'd2);
    access(1, 3'd5);
    checkId("R6 unreported tx kept across ident read", 4'b0010);
    access(0, 3'd0);
    access(1, 3'd6);
    checkId("R11 all clear", 4'b0001);

    // line status and received data
    lineErrors = 4'b0100; step();
    checkId("R3 line set", 4'b0110);
    repeat (3) step();
    checkId("R3 line sticky", 4'b0110);
    rxPush = 1; step();
    checkId("R2 line above rx data", 4'b0110);
    busRead = 1; regSel = 3'd5; lineErrors = 4'b1000; step();
    checkId("R3 new error wins over read", 4'b0110);
    access(1, 3'd5);
    checkId("R4 rx data after line read", 4'b0100);
    access(1, 3'd0);
    checkId("R4 rx data cleared by buffer read", 4'b0001);

    // enables
    irqEnable = 4'b0000;
    lineErrors = 4'b0010; step();
    checkId("R10 disabled line not reported", 4'b0001);
    irqEnable = 4'b0100; #1;
    checkId("R10 enabling shows latched line", 4'b0110);
    access(1, 3'd5);
    irqEnable = 4'hF;
    uartBusy = 1; access(0, 3'd3); uartBusy = 0;
    irqEnable = 4'h0; #1;
    checkId("R10 busy always enabled", 4'b0111);
    irqEnable = 4'hF;
    modemDelta = 4'b0001; step();
    checkId("R2 modem above busy", 4'b0000);
    access(1, 3'd6);
    access(1, 3'd7);
    checkId("R9 busy cleared again", 4'b0001);

    // FIFO mode received data level
    fifoEnable = 1; rxAtTrigger = 1; #1;
    checkId("R4 fifo level reported", 4'b0100);
    rxAtTrigger = 0; #1;
    checkId("R4 fifo level dropped", 4'b0001);

    // character timeout
    rxNotEmpty = 1; rxPush = 1; step();
    repeat (3) begin charTick = 1; step(); end
    checkId("R5 no timeout after 3 ticks", 4'b0001);
    rxPop = 1; step();
    repeat (3) begin charTick = 1; step(); end
    checkId("R5 restart after pop", 4'b0001);
    charTick = 1; step();
    checkId("R5 timeout after 4th tick", 4'b1100);
    rxAtTrigger = 1; #1;
    checkId("R2 timeout above rx data", 4'b1100);
    access(1, 3'd0);
    checkId("R5 timeout cleared by buffer read", 4'b0100);
    rxAtTrigger = 0; rxNotEmpty = 0; step();

    // threshold mode
    txThreshMode = 1; txAtThresh = 1; #1;
    checkId("R7 threshold level reported", 4'b0010);
    access(1, 3'd2);
    checkId("R7 ident read does not clear level", 4'b0010);
    txAtThresh = 0; #1;
    checkId("R7 above threshold clears", 4'b0001);
    txThreshMode = 0; fifoEnable = 0;

    // random traffic against the reference state
    for (int i = 0; i < 4000; i++) begin
      if (i % 250 == 0) begin
        fifoEnable   = $urandom_range(0, 1);
        txThreshMode = $urandom_range(0, 1);
        irqEnable    = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'hF;
      end
      if ($urandom_range(0, 3) == 0) begin
        if ($urandom_range(0, 1)) busRead = 1; else busWrite = 1;
        regSel = 3'($urandom);
      end
      if ($urandom_range(0, 31) == 0) lineErrors = 4'($urandom);
      if ($urandom_range(0, 15) == 0) rxPush = 1;
      if ($urandom_range(0, 15) == 0) rxPop = 1;
      if ($urandom_range(0, 31) == 0) modemDelta = 4'($urandom);
      if ($urandom_range(0, 7) == 0) txEmpty = ~txEmpty;
      charTick    = ($urandom_range(0, 3) == 0);
      rxNotEmpty  = ($urandom_range(0, 7) != 0);
      rxAtTrigger = ($urandom_range(0, 7) == 0);
      txAtThresh  = ($urandom_range(0, 3) == 0);
      uartBusy    = $urandom_range(0, 1);
      step();
      checkId("R11 random model", expId());
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule